// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block sits next to the dispatch stage of an out-of-order core and decides, for each dispatched load or store, whether it must be held behind a specific earlier store. It learns from ordering violations: when the load/store queue reports that a load read memory ahead of a store that wrote the same address, the block places both instruction addresses into a common group. A direct-mapped group-number table, indexed by a fold of the instruction word address, maps each load or store to its group. A second table, indexed by group number, remembers the tag of the youngest store of that group that has been dispatched and has not yet issued.

A dispatched load whose group has a live youngest store is told to wait on that store's tag. A dispatched store is told to wait on the previous youngest store of its group, and then takes that place itself. When a store issues, it removes itself from the second table, but only if no younger store of the group has already replaced it. A periodic flush input forgets all learned grouping. Loads that are not told to wait are left to ordinary speculation in the queue.

Top module: `mdp_store_set_predictor`

## Requirements
- R1: After reset `res_valid` is 0, both tables are empty, and a dispatch then reports `res_wait` = 0.
- R2: Every cycle with `disp_valid` = 1 produces exactly one result on the next cycle (`res_valid` = 1 with `res_wait`, `res_tag`). Cycles without a dispatch give `res_valid` = 0 next cycle.
- R3: The table index is the XOR fold of the word address: bit i of the address toggles index bit (i mod IDX_W). Addresses with equal folds share one entry (defaults: address 512 and address 8 both use entry 8).
- R4: A load or store whose address has no group, or whose group has no live youngest store, reports `res_wait` = 0.
- R5: A violation in which neither address has a group assigns both a fresh group number. Fresh numbers come from a counter that starts at 0 after reset and advances by one per fresh assignment.
- R6: A violation in which exactly one address has a group gives the other address that same group.
- R7: A violation in which both addresses have groups moves both to the numerically smaller group.
- R8: A dispatched store with a group reports the group's current youngest store (if any) as its own dependency and becomes the youngest store. A later load of the group then waits on that store's tag.
- R9: An issuing store clears its group's youngest-store entry only when that entry holds the issuing store's tag. Otherwise the entry is unchanged.
- R10: `ssid_flush` forgets every address-to-group mapping, and a violation reported in the same cycle is dropped. The fresh-number counter is not reset.
- R11: A dispatch sees table contents from before any update made in the same cycle. When a store dispatch and a store issue target the same group in one cycle, the dispatching store's entry is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A load or store dispatches this cycle |
| disp_store | input | 1 | 1 = dispatching a store, 0 = a load |
| disp_pc | input | PCA_W | Word address of the dispatching instruction |
| disp_tag | input | TAG_W | Instruction tag of the dispatching instruction |
| issue_valid | input | 1 | A store issues (its address resolves) this cycle |
| issue_pc | input | PCA_W | Word address of the issuing store |
| issue_tag | input | TAG_W | Tag of the issuing store |
| viol_valid | input | 1 | An ordering violation is reported |
| viol_ld_pc | input | PCA_W | Word address of the load involved |
| viol_st_pc | input | PCA_W | Word address of the store involved |
| ssid_flush | input | 1 | Forget all address-to-group mappings |
| res_valid | output | 1 | Result for the dispatch of the previous cycle |
| res_wait | output | 1 | The instruction must wait on `res_tag` |
| res_tag | output | TAG_W | Tag of the store to wait on |

## Verification
A wrong group number in the first table shows up only on a later dispatch: a load is told to wait on a store it never conflicted with, or runs free where it should wait. The one-cycle result lets the scoreboard attach that error to the exact dispatch. A youngest-store entry that is cleared by the wrong store, or not replaced by a new store, appears as a stale or missing `res_tag` on the next load of that group. Violation merges are exercised so that the smaller-number rule is visible: a store that keeps its old group pulls an unrelated earlier load into waiting.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

  // How a violation report combines the two group lookups
  typedef enum logic [1:0] {
    MRG_FRESH = 2'd0,
    MRG_LOAD  = 2'd1,
    MRG_STORE = 2'd2,
    MRG_MIN   = 2'd3
  } merge_e;

endpackage

// File: rtl/mdp_ssid_table.sv
module mdp_ssid_table #(
  parameter int IDX_W  = 6,
  parameter int SSID_W = 4,
  parameter int NRD    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx  [NRD],
  output logic              rd_vld  [NRD],
  output logic [SSID_W-1:0] rd_ssid [NRD],
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx_a,
  input  logic [IDX_W-1:0]  wr_idx_b,
  input  logic [SSID_W-1:0] wr_ssid
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [SSID_W-1:0] id_q [DEPTH];
  logic [SSID_W-1:0] id_d [DEPTH];
  logic              id_en;

  assign id_en = wr_en && !clr;

  always_comb begin
    vld_d = vld_q;
    id_d  = id_q;
    if (clr) begin
      vld_d = '0;
    end else if (wr_en) begin
      vld_d[wr_idx_a] = 1'b1;
      vld_d[wr_idx_b] = 1'b1;
      id_d[wr_idx_a]  = wr_ssid;
      id_d[wr_idx_b]  = wr_ssid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (id_en) id_q <= id_d;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_vld[r]  = vld_q[rd_idx[r]];
    assign rd_ssid[r] = id_q[rd_idx[r]];
  end

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));

  // R5
  pair_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (vld_q[$past(wr_idx_a)] && vld_q[$past(wr_idx_b)] &&
                         id_q[$past(wr_idx_a)] == id_q[$past(wr_idx_b)]));

endmodule

// File: rtl/mdp_last_store.sv
module mdp_last_store #(
  parameter int SSID_W = 4,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SSID_W-1:0] rd_ssid,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  input  logic              wr_en,
  input  logic [SSID_W-1:0] wr_ssid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              kill_en,
  input  logic [SSID_W-1:0] kill_ssid,
  input  logic [TAG_W-1:0]  kill_tag
);
  localparam int DEPTH = 1 << SSID_W;

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic             kill_hit;

  assign kill_hit = kill_en && vld_q[kill_ssid] && (tag_q[kill_ssid] == kill_tag);

  always_comb begin
    vld_d = vld_q;
    if (kill_hit) vld_d[kill_ssid] = 1'b0;
    if (wr_en)    vld_d[wr_ssid]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_ssid] <= wr_tag;
  end

  assign rd_vld = vld_q[rd_ssid];
  assign rd_tag = tag_q[rd_ssid];

  // R8
  claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_ssid)] && tag_q[$past(wr_ssid)] == $past(wr_tag)));

  // R9
  foreign_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_en && !wr_en && !(vld_q[kill_ssid] && tag_q[kill_ssid] == kill_tag))
      |=> $stable(vld_q));

endmodule

// File: rtl/mdp_viol_merge.sv
module mdp_viol_merge
  import mdp_pkg::*;
#(
  parameter int SSID_W = 4
) (
  input  logic              ld_vld,
  input  logic [SSID_W-1:0] ld_ssid,
  input  logic              st_vld,
  input  logic [SSID_W-1:0] st_ssid,
  input  logic [SSID_W-1:0] fresh_ssid,
  output logic [SSID_W-1:0] tgt_ssid,
  output logic              take_fresh
);
  merge_e kind;

  always_comb begin
    unique case ({ld_vld, st_vld})
      2'b00:   kind = MRG_FRESH;
      2'b10:   kind = MRG_LOAD;
      2'b01:   kind = MRG_STORE;
      default: kind = MRG_MIN;
    endcase
  end

  always_comb begin
    take_fresh = 1'b0;
    unique case (kind)
      MRG_FRESH: begin
        tgt_ssid   = fresh_ssid;
        take_fresh = 1'b1;
      end
      MRG_LOAD:  tgt_ssid = ld_ssid;
      MRG_STORE: tgt_ssid = st_ssid;
      default:   tgt_ssid = (ld_ssid < st_ssid) ? ld_ssid : st_ssid;
    endcase
  end

endmodule

// File: rtl/mdp_store_set_predictor.sv
module mdp_store_set_predictor #(
  parameter int PCA_W  = 30,
  parameter int IDX_W  = 6,
  parameter int SSID_W = 4,
  parameter int TAG_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic             disp_store,
  input  logic [PCA_W-1:0] disp_pc,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic             issue_valid,
  input  logic [PCA_W-1:0] issue_pc,
  input  logic [TAG_W-1:0] issue_tag,
  input  logic             viol_valid,
  input  logic [PCA_W-1:0] viol_ld_pc,
  input  logic [PCA_W-1:0] viol_st_pc,
  input  logic             ssid_flush,
  output logic             res_valid,
  output logic             res_wait,
  output logic [TAG_W-1:0] res_tag
);
  localparam int NRD   = 4;
  localparam int P_DSP = 0;
  localparam int P_ISS = 1;
  localparam int P_VLD = 2;
  localparam int P_VST = 3;

  function automatic logic [IDX_W-1:0] fold_idx(input logic [PCA_W-1:0] a);
    logic [IDX_W-1:0] f;
    f = '0;
    for (int i = 0; i < PCA_W; i++) f[i % IDX_W] = f[i % IDX_W] ^ a[i];
    return f;
  endfunction

  logic [IDX_W-1:0]  rd_idx  [NRD];
  logic              t_vld   [NRD];
  logic [SSID_W-1:0] t_ssid  [NRD];

  logic              lf_vld;
  logic [TAG_W-1:0]  lf_tag;
  logic              lf_wr, lf_kill;

  logic [SSID_W-1:0] tgt_ssid;
  logic              take_fresh;
  logic [SSID_W-1:0] nxt_q, nxt_d;
  logic              nxt_en;

  logic              res_wait_d;
  logic              res_valid_q, res_wait_q;
  logic [TAG_W-1:0]  res_tag_q;

  assign rd_idx[P_DSP] = fold_idx(disp_pc);
  assign rd_idx[P_ISS] = fold_idx(issue_pc);
  assign rd_idx[P_VLD] = fold_idx(viol_ld_pc);
  assign rd_idx[P_VST] = fold_idx(viol_st_pc);

  mdp_ssid_table #(.IDX_W(IDX_W), .SSID_W(SSID_W), .NRD(NRD)) u_ssit (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ssid_flush),
    .rd_idx   (rd_idx),
    .rd_vld   (t_vld),
    .rd_ssid  (t_ssid),
    .wr_en    (viol_valid),
    .wr_idx_a (rd_idx[P_VLD]),
    .wr_idx_b (rd_idx[P_VST]),
    .wr_ssid  (tgt_ssid)
  );

  assign lf_wr   = disp_valid && disp_store && t_vld[P_DSP];
  assign lf_kill = issue_valid && t_vld[P_ISS];

  mdp_last_store #(.SSID_W(SSID_W), .TAG_W(TAG_W)) u_lfst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_ssid   (t_ssid[P_DSP]),
    .rd_vld    (lf_vld),
    .rd_tag    (lf_tag),
    .wr_en     (lf_wr),
    .wr_ssid   (t_ssid[P_DSP]),
    .wr_tag    (disp_tag),
    .kill_en   (lf_kill),
    .kill_ssid (t_ssid[P_ISS]),
    .kill_tag  (issue_tag)
  );

  mdp_viol_merge #(.SSID_W(SSID_W)) u_merge (
    .ld_vld     (t_vld[P_VLD]),
    .ld_ssid    (t_ssid[P_VLD]),
    .st_vld     (t_vld[P_VST]),
    .st_ssid    (t_ssid[P_VST]),
    .fresh_ssid (nxt_q),
    .tgt_ssid   (tgt_ssid),
    .take_fresh (take_fresh)
  );

  // Fresh group number counter
  always_comb begin
    nxt_en = viol_valid && !ssid_flush && take_fresh;
    nxt_d  = nxt_q + SSID_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nxt_q <= '0;
    else if (nxt_en) nxt_q <= nxt_d;
  end

  // Dispatch result, one cycle later
  assign res_wait_d = t_vld[P_DSP] && lf_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid_q <= 1'b0;
    else        res_valid_q <= disp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_wait_q <= 1'b0;
      res_tag_q  <= '0;
    end else if (disp_valid) begin
      res_wait_q <= res_wait_d;
      res_tag_q  <= lf_tag;
    end
  end

  assign res_valid = res_valid_q;
  assign res_wait  = res_wait_q;
  assign res_tag   = res_tag_q;

  // R2
  res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> res_valid);

  // R2
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid |=> !res_valid);

  // R4
  no_group_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !t_vld[P_DSP]) |=> !res_wait);

  // R7
  min_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && t_vld[P_VLD] && t_vld[P_VST])
      |-> (tgt_ssid <= t_ssid[P_VLD] && tgt_ssid <= t_ssid[P_VST]));

  // R5
  alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !ssid_flush && !t_vld[P_VLD] && !t_vld[P_VST])
      |=> (nxt_q == $past(nxt_q) + SSID_W'(1)));

endmodule

// File: tb/sim_mdp_store_set_predictor.sv
`timescale 1ns/1ps
module sim_mdp_store_set_predictor;
  localparam int PCA_W = 30;
  localparam int TAG_W = 6;

  typedef struct {
    bit              w;
    logic [TAG_W-1:0] t;
    string           rq;
  } exp_t;

  logic             clk, rst_n;
  logic             disp_valid, disp_store;
  logic [PCA_W-1:0] disp_pc;
  logic [TAG_W-1:0] disp_tag;
  logic             issue_valid;
  logic [PCA_W-1:0] issue_pc;
  logic [TAG_W-1:0] issue_tag;
  logic             viol_valid;
  logic [PCA_W-1:0] viol_ld_pc, viol_st_pc;
  logic             ssid_flush;
  logic             res_valid, res_wait;
  logic [TAG_W-1:0] res_tag;

  int   n_chk  = 0;
  int   n_fail = 0;
  exp_t exp_q[$];

  // Word addresses below 64 map to entry = address (R3 fold)
  localparam logic [PCA_W-1:0] LA = 30'd8;
  localparam logic [PCA_W-1:0] LA_ALIAS = 30'd512;
  localparam logic [PCA_W-1:0] SA = 30'd9;
  localparam logic [PCA_W-1:0] LB = 30'd10;
  localparam logic [PCA_W-1:0] LC = 30'd11;
  localparam logic [PCA_W-1:0] SC = 30'd12;
  localparam logic [PCA_W-1:0] LD = 30'd13;

  mdp_store_set_predictor u0 (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_store(disp_store), .disp_pc(disp_pc), .disp_tag(disp_tag),
    .issue_valid(issue_valid), .issue_pc(issue_pc), .issue_tag(issue_tag),
    .viol_valid(viol_valid), .viol_ld_pc(viol_ld_pc), .viol_st_pc(viol_st_pc),
    .ssid_flush(ssid_flush),
    .res_valid(res_valid), .res_wait(res_wait), .res_tag(res_tag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: pops one expectation per result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: result with no dispatch, wait=%0d tag=%0d expected none",
                 res_wait, res_tag);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (res_wait !== e.w || (e.w && res_tag !== e.t)) begin
          n_fail++;
          $display("FAIL %s: wait=%0d tag=%0d expected wait=%0d tag=%0d",
                   e.rq, res_wait, res_tag, e.w, e.t);
        end
      end
    end
  end

  task automatic go(input logic dv, input logic ds, input logic [PCA_W-1:0] dp,
                    input logic [TAG_W-1:0] dt,
                    input logic iv, input logic [PCA_W-1:0] ip, input logic [TAG_W-1:0] it,
                    input logic vv, input logic [PCA_W-1:0] vl, input logic [PCA_W-1:0] vs,
                    input logic fl, input bit ew, input logic [TAG_W-1:0] et, input string rq);
    exp_t e;
    @(negedge clk);
    disp_valid  = dv; disp_store = ds; disp_pc = dp; disp_tag = dt;
    issue_valid = iv; issue_pc = ip; issue_tag = it;
    viol_valid  = vv; viol_ld_pc = vl; viol_st_pc = vs;
    ssid_flush  = fl;
    if (dv) begin
      e.w = ew; e.t = et; e.rq = rq;
      exp_q.push_back(e);
    end
  endtask

  task automatic ld(input logic [PCA_W-1:0] pc, input logic [TAG_W-1:0] tg,
                    input bit ew, input logic [TAG_W-1:0] et, input string rq);
    go(1'b1, 1'b0, pc, tg, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, ew, et, rq);
  endtask

  task automatic st(input logic [PCA_W-1:0] pc, input logic [TAG_W-1:0] tg,
                    input bit ew, input logic [TAG_W-1:0] et, input string rq);
    go(1'b1, 1'b1, pc, tg, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, ew, et, rq);
  endtask

  task automatic iss(input logic [PCA_W-1:0] pc, input logic [TAG_W-1:0] tg);
    go(1'b0, 1'b0, '0, '0, 1'b1, pc, tg, 1'b0, '0, '0, 1'b0, 1'b0, '0, "");
  endtask

  task automatic viol(input logic [PCA_W-1:0] l, input logic [PCA_W-1:0] s);
    go(1'b0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, l, s, 1'b0, 1'b0, '0, "");
  endtask

  task automatic idle();
    go(1'b0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0, '0, "");
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    disp_valid = 0; disp_store = 0; disp_pc = '0; disp_tag = '0;
    issue_valid = 0; issue_pc = '0; issue_tag = '0;
    viol_valid = 0; viol_ld_pc = '0; viol_st_pc = '0; ssid_flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: res_valid=%0d expected 0", res_valid);
    end

    ld(LA, 6'd1, 0, 0, "R1");
    st(SA, 6'd2, 0, 0, "R4");
    viol(LA, SA);                       // R5: fresh group 0
    ld(LA, 6'd3, 0, 0, "R4");
    st(SA, 6'd4, 0, 0, "R8");
    ld(LA, 6'd5, 1, 6'd4, "R8");
    ld(LA_ALIAS, 6'd6, 1, 6'd4, "R3");
    st(SA, 6'd7, 1, 6'd4, "R8");
    iss(SA, 6'd4);                      // R9: stale tag, no clear
    ld(LA, 6'd8, 1, 6'd7, "R9");
    iss(SA, 6'd7);
    ld(LA, 6'd9, 0, 0, "R9");
    viol(LB, SA);                       // R6: LB joins group 0
    st(SA, 6'd10, 0, 0, "R9");
    ld(LB, 6'd11, 1, 6'd10, "R6");
    viol(LC, SC);                       // R5: fresh group 1
    st(SC, 6'd12, 0, 0, "R5");
    ld(LC, 6'd13, 1, 6'd12, "R5");
    viol(LC, SA);                       // R7: both to group 0
    ld(LC, 6'd14, 1, 6'd10, "R7");
    st(SA, 6'd15, 1, 6'd10, "R7");
    ld(LA, 6'd16, 1, 6'd15, "R7");
    // R11: store dispatch and issue of older store in same group
    go(1, 1, SA, 6'd17, 1, SA, 6'd15, 0, '0, '0, 0, 1, 6'd15, "R11");
    ld(LA, 6'd18, 1, 6'd17, "R11");
    // R11: load dispatch sees entry before same-cycle clear
    go(1, 0, LB, 6'd19, 1, SA, 6'd17, 0, '0, '0, 0, 1, 6'd17, "R11");
    ld(LB, 6'd20, 0, 0, "R9");
    // R11: load dispatch sees table before same-cycle violation
    go(1, 0, LD, 6'd21, 0, '0, '0, 1, LD, SA, 0, 0, 0, "R11");
    st(SA, 6'd22, 0, 0, "R6");
    ld(LD, 6'd23, 1, 6'd22, "R6");
    // R10: flush forgets grouping
    go(0, 0, '0, '0, 0, '0, '0, 0, '0, '0, 1, 0, 0, "");
    ld(LA, 6'd24, 0, 0, "R10");
    st(SA, 6'd25, 0, 0, "R10");
    viol(LA, SA);
    st(SA, 6'd26, 0, 0, "R10");
    ld(LA, 6'd27, 1, 6'd26, "R10");
    // R10: violation in a flush cycle is dropped
    go(0, 0, '0, '0, 0, '0, '0, 1, LC, SC, 1, 0, 0, "");
    st(SC, 6'd29, 0, 0, "R10");
    ld(LC, 6'd30, 0, 0, "R10");
    idle();
    idle();
    idle();
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule